// File: doc/BRIEF.md
# Decision-Feedback Equalizer Filter Datapath

This block forms the soft output of a decision-feedback equalizer. A feedforward section runs received samples through a delay line and a bank of signed multipliers. A feedback section does the same with past symbol decisions, so it can cancel the interference that trails each symbol. Each feedforward product is cut to a 17-bit term with 15 fractional bits. Each feedback product is already in Q15, so it is kept whole. All terms are added at full precision, and the total is registered as the equalizer output.

Both delay lines advance together on one enable, which marks the arrival of a new sample and its matching decision. The coefficient vectors come in parallel from an external register bank and are applied as they stand. The slicer, the error computation and the coefficient adaptation sit outside this block. Both tap counts are parameters.

Top module: `dfe_filter_core`

## Requirements
- R1: While `rst_n` is low and after it is released, both delay lines hold zero, `eq_valid` is 0 and `eq_out` is 0. They stay that way until the first result of a shift appears.
- R2: At each rising edge with `shift_en` high, `sample_in` enters feedforward entry 0 and `decision_in` enters feedback entry 0. Every other entry i takes the value of entry i-1, and the oldest value is lost.
- R3: At each rising edge with `shift_en` low, neither delay line changes, whatever `sample_in` and `decision_in` carry. `eq_out` keeps its value during such cycles.
- R4: Feedforward tap i forms the 28-bit signed product of entry i (12-bit, Q10) and its coefficient (16-bit, Q15). It keeps product bits 26 down to 10 as a signed 17-bit Q15 term. This floors toward minus infinity, and the single product +2^26 wraps to -65536.
- R5: Feedback tap i forms the exact 18-bit signed product of entry i (2-bit signed symbol, values -2..1) and its Q15 coefficient. That product is used as a Q15 term without truncation.
- R6: `eq_out` is the exact signed sum of all feedforward and feedback terms. It is 25 bits wide for the default 32/64 taps and never overflows.
- R7: `eq_out` is updated and `eq_valid` is high exactly one cycle after a shifting edge. `eq_valid` is low in every other cycle.
- R8: Coefficient i of each section occupies bits [16i+15:16i] of its vector. Tap 0 pairs with the newest delay-line entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Advance both delay lines this cycle |
| sample_in | input | 12 | Received sample, signed Q10 |
| decision_in | input | 2 | Past symbol decision, signed integer |
| ff_coef | input | FF_TAPS*16 | Feedforward coefficients, Q15, tap i at [16i+15:16i] |
| fb_coef | input | FB_TAPS*16 | Feedback coefficients, Q15, tap i at [16i+15:16i] |
| eq_out | output | OUT_W (25) | Soft equalizer output, signed Q15 |
| eq_valid | output | 1 | High for one cycle when `eq_out` carries a new result |

## Verification
The timing and zero-state properties assume that `shift_en` and the data inputs are settled before each rising edge. They also assume that reset starts every run. The bench drives all inputs on the falling edge to meet this.

The bench changes the coefficient vectors only after every pending result has come out. This keeps each expected sum tied to one coefficient set. During idle cycles the bench puts random data on the sample and decision inputs, which shows that a low enable really ignores them. Extreme corners drive full-scale values: -2048 samples against -32768 coefficients, and -2 decisions against -32768 coefficients. These reach the truncation wrap and the largest feedback terms.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
   localparam int FF_TAPS_DEF = 32;
   localparam int FB_TAPS_DEF = 64;
   localparam int SAMP_W_DEF  = 12;
   localparam int COEF_W_DEF  = 16;
   localparam int DEC_W_DEF   = 2;
   localparam int FF_DROP_DEF = 10;
   localparam int FF_TERM_DEF = 17;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/dfe_delay_line.sv
module dfe_delay_line #(
   parameter int WIDTH = 12,
   parameter int DEPTH = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     shift_en,
   input  logic [WIDTH-1:0]         din,
   output logic [DEPTH*WIDTH-1:0]   taps_flat
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("dfe_delay_line: DEPTH must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("dfe_delay_line: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
      end else if (shift_en) begin
         stage[0] <= din;
         for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign taps_flat[g*WIDTH +: WIDTH] = stage[g];
   end
endmodule

// File: rtl/dfe_tap_bank.sv
module dfe_tap_bank #(
   parameter int TAPS    = 32,
   parameter int SAMP_W  = 12,
   parameter int COEF_W  = 16,
   parameter int DROP    = 10,
   parameter int TERM_W  = 17,
   parameter int SUM_W   = TERM_W + $clog2(TAPS)
) (
   input  logic [TAPS*SAMP_W-1:0]  samp_flat,
   input  logic [TAPS*COEF_W-1:0]  coef_flat,
   output logic signed [SUM_W-1:0] sum
);
   localparam int PROD_W = SAMP_W + COEF_W;

   if (DROP + TERM_W > PROD_W) begin : g_bad_slice
      $error("dfe_tap_bank: kept slice exceeds the product width");
   end
   if (SUM_W < TERM_W + $clog2(TAPS)) begin : g_bad_sum
      $error("dfe_tap_bank: SUM_W too narrow for TAPS terms");
   end

   logic signed [TERM_W-1:0] term [TAPS];

   for (genvar g = 0; g < TAPS; g++) begin : g_tap
      logic signed [SAMP_W-1:0] s;
      logic signed [COEF_W-1:0] c;
      logic signed [PROD_W-1:0] p;
      assign s = samp_flat[g*SAMP_W +: SAMP_W];
      assign c = coef_flat[g*COEF_W +: COEF_W];
      assign p = s * c;
      if (DROP == 0) begin : g_exact
         assign term[g] = TERM_W'(p);
      end else begin : g_trunc
         assign term[g] = TERM_W'(p >>> DROP);
      end
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < TAPS; i++) sum = sum + SUM_W'(term[i]);
   end
endmodule

// File: rtl/dfe_filter_core.sv
module dfe_filter_core #(
   parameter int FF_TAPS   = dfe_pkg::FF_TAPS_DEF,
   parameter int FB_TAPS   = dfe_pkg::FB_TAPS_DEF,
   parameter int SAMP_W    = dfe_pkg::SAMP_W_DEF,
   parameter int COEF_W    = dfe_pkg::COEF_W_DEF,
   parameter int DEC_W     = dfe_pkg::DEC_W_DEF,
   parameter int FF_DROP   = dfe_pkg::FF_DROP_DEF,
   parameter int FF_TERM_W = dfe_pkg::FF_TERM_DEF,
   localparam int FB_TERM_W = DEC_W + COEF_W,
   localparam int FF_SUM_W  = FF_TERM_W + $clog2(FF_TAPS),
   localparam int FB_SUM_W  = FB_TERM_W + $clog2(FB_TAPS),
   localparam int OUT_W     = dfe_pkg::max_i(FF_SUM_W, FB_SUM_W) + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       shift_en,
   input  logic [SAMP_W-1:0]          sample_in,
   input  logic [DEC_W-1:0]           decision_in,
   input  logic [FF_TAPS*COEF_W-1:0]  ff_coef,
   input  logic [FB_TAPS*COEF_W-1:0]  fb_coef,
   output logic [OUT_W-1:0]           eq_out,
   output logic                       eq_valid
);
   if (FF_TAPS < 1 || FB_TAPS < 1) begin : g_bad_taps
      $error("dfe_filter_core: both sections need at least one tap");
   end

   logic [FF_TAPS*SAMP_W-1:0]  ff_line;
   logic [FB_TAPS*DEC_W-1:0]   fb_line;
   logic signed [FF_SUM_W-1:0] ff_sum;
   logic signed [FB_SUM_W-1:0] fb_sum;
   logic signed [OUT_W-1:0]    total;
   logic                       shifted_q;

   dfe_delay_line #(.WIDTH(SAMP_W), .DEPTH(FF_TAPS)) u_ff_line (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
      .din(sample_in), .taps_flat(ff_line));

   dfe_delay_line #(.WIDTH(DEC_W), .DEPTH(FB_TAPS)) u_fb_line (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
      .din(decision_in), .taps_flat(fb_line));

   dfe_tap_bank #(.TAPS(FF_TAPS), .SAMP_W(SAMP_W), .COEF_W(COEF_W),
                  .DROP(FF_DROP), .TERM_W(FF_TERM_W), .SUM_W(FF_SUM_W)) u_ff_bank (
      .samp_flat(ff_line), .coef_flat(ff_coef), .sum(ff_sum));

   dfe_tap_bank #(.TAPS(FB_TAPS), .SAMP_W(DEC_W), .COEF_W(COEF_W),
                  .DROP(0), .TERM_W(FB_TERM_W), .SUM_W(FB_SUM_W)) u_fb_bank (
      .samp_flat(fb_line), .coef_flat(fb_coef), .sum(fb_sum));

   assign total = OUT_W'(ff_sum) + OUT_W'(fb_sum);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shifted_q <= 1'b0;
         eq_valid  <= 1'b0;
         eq_out    <= '0;
      end else begin
         shifted_q <= shift_en;
         eq_valid  <= shifted_q;
         if (shifted_q) eq_out <= total;
      end
   end
endmodule

// File: rtl/dfe_filter_chk.sv
module dfe_filter_chk #(
   parameter int SAMP_W = 12,
   parameter int DEC_W  = 2,
   parameter int OUT_W  = 25
) (
   input logic              clk,
   input logic              rst_n,
   input logic              shift_en,
   input logic [SAMP_W-1:0] sample_in,
   input logic [DEC_W-1:0]  decision_in,
   input logic [SAMP_W-1:0] ff_head,
   input logic [DEC_W-1:0]  fb_head,
   input logic              lines_moved,
   input logic [OUT_W-1:0]  eq_out,
   input logic              eq_valid
);
   logic seen_result;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seen_result <= 1'b0;
      else if (eq_valid) seen_result <= 1'b1;
   end

   // R1: output held at zero until the first result
   a_r1_zero_before_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen_result && !eq_valid) |-> (eq_out == '0));

   // R2: newest entries take the inputs present at the shifting edge
   a_r2_head_loads: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (ff_head == $past(sample_in)) && (fb_head == $past(decision_in)));

   // R3: no movement without enable
   a_r3_hold_lines: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> !lines_moved);

   // R3: output stable outside result cycles
   a_r3_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !eq_valid |-> $stable(eq_out));

   // R7: result one cycle after the shifting edge
   a_r7_valid_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |-> ##2 eq_valid);

   // R7: no result without a prior shift
   a_r7_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |-> ##2 !eq_valid);
endmodule

module dfe_filter_core_probe #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] vec,
   output logic         moved
);
   logic [W-1:0] prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= vec;
   end
   assign moved = (prev != vec);
endmodule

bind dfe_filter_core dfe_filter_chk #(.SAMP_W(SAMP_W), .DEC_W(DEC_W), .OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
   .sample_in(sample_in), .decision_in(decision_in),
   .ff_head(ff_line[SAMP_W-1:0]), .fb_head(fb_line[DEC_W-1:0]),
   .lines_moved(u_probe.moved),
   .eq_out(eq_out), .eq_valid(eq_valid));

bind dfe_filter_core dfe_filter_core_probe #(.W(FF_TAPS*SAMP_W + FB_TAPS*DEC_W)) u_probe (
   .clk(clk), .rst_n(rst_n), .vec({ff_line, fb_line}), .moved());

// File: tb/sim_dfe_filter_core.sv
module sim_dfe_filter_core;
   localparam int FF_TAPS = 32;
   localparam int FB_TAPS = 64;
   localparam int OUT_W   = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shift_en = 1'b0;
   logic [11:0] sample_in = '0;
   logic [1:0]  decision_in = '0;
   logic [FF_TAPS*16-1:0] ff_coef = '0;
   logic [FB_TAPS*16-1:0] fb_coef = '0;
   logic [OUT_W-1:0] eq_out;
   logic eq_valid;

   always #4 clk = ~clk;

   dfe_filter_core u0 (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
      .sample_in(sample_in), .decision_in(decision_in),
      .ff_coef(ff_coef), .fb_coef(fb_coef),
      .eq_out(eq_out), .eq_valid(eq_valid));

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;
   longint expq [$];
   logic [OUT_W-1:0] last_out = '0;

   logic signed [11:0] m_ff [FF_TAPS];
   logic signed [1:0]  m_fb [FB_TAPS];

   function automatic longint model_sum();
      longint acc = 0;
      for (int i = 0; i < FF_TAPS; i++) begin
         logic signed [15:0] c;
         logic signed [27:0] p;
         logic signed [16:0] t;
         c = ff_coef[i*16 +: 16];
         p = m_ff[i] * c;
         t = p[26:10];               // R4 kept slice
         acc += longint'(t);
      end
      for (int i = 0; i < FB_TAPS; i++) begin
         logic signed [15:0] c;
         logic signed [17:0] p;
         c = fb_coef[i*16 +: 16];
         p = m_fb[i] * c;            // R5 exact product
         acc += longint'(p);
      end
      return acc;
   endfunction

   task automatic shift_one(input logic [11:0] s, input logic [1:0] d);
      @(negedge clk);
      sample_in = s;
      decision_in = d;
      shift_en = 1'b1;
      for (int i = FF_TAPS-1; i > 0; i--) m_ff[i] = m_ff[i-1];
      for (int i = FB_TAPS-1; i > 0; i--) m_fb[i] = m_fb[i-1];
      m_ff[0] = s;
      m_fb[0] = d;
      expq.push_back(model_sum());
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         shift_en = 1'b0;
         sample_in = 12'($urandom);
         decision_in = 2'($urandom);
      end
   endtask

   task automatic drain();
      idle(4);
   endtask

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: R6 R7 R3 R8 results checked against scoreboard
   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         if (eq_valid) begin
            if (expq.size() == 0) begin
               check(1'b0, "R7 stray valid", longint'($signed(eq_out)), 0);
            end else begin
               longint e;
               e = expq.pop_front();
               check(longint'($signed(eq_out)) == e, "R6 sum", longint'($signed(eq_out)), e);
            end
            last_out = eq_out;
         end else begin
            check(eq_out == last_out, "R3 output hold",
                  longint'($signed(eq_out)), longint'($signed(last_out)));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < FF_TAPS; i++) m_ff[i] = '0;
      for (int i = 0; i < FB_TAPS; i++) m_fb[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(eq_out == '0 && eq_valid == 1'b0, "R1 in reset", longint'(eq_out), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(eq_out == '0 && eq_valid == 1'b0, "R1 after release", longint'(eq_out), 0);
      mon_on = 1'b1;

      // R1 R2 R6: random coefficients, back-to-back shifts from cleared lines
      for (int i = 0; i < FF_TAPS; i++) ff_coef[i*16 +: 16] = 16'($urandom);
      for (int i = 0; i < FB_TAPS; i++) fb_coef[i*16 +: 16] = 16'($urandom);
      for (int k = 0; k < 120; k++) shift_one(12'($urandom), 2'($urandom));
      drain();

      // R3: shifts separated by idle cycles carrying junk inputs
      for (int k = 0; k < 40; k++) begin
         shift_one(12'($urandom), 2'($urandom));
         idle(1 + (k % 3));
      end
      drain();

      // R4 wrap corner and R5 largest feedback terms
      for (int i = 0; i < FF_TAPS; i++) ff_coef[i*16 +: 16] = 16'h8000;
      for (int i = 0; i < FB_TAPS; i++) fb_coef[i*16 +: 16] = 16'h8000;
      for (int k = 0; k < 70; k++) shift_one(12'h800, 2'b10);
      drain();

      // R4 floor: sample -1 with coefficient 1 on every tap
      for (int i = 0; i < FF_TAPS; i++) ff_coef[i*16 +: 16] = 16'h0001;
      for (int i = 0; i < FB_TAPS; i++) fb_coef[i*16 +: 16] = 16'h7fff;
      for (int k = 0; k < 70; k++) shift_one(12'hfff, 2'b01);
      drain();

      // R8 ordering: single nonzero tap per section
      ff_coef = '0;
      fb_coef = '0;
      ff_coef[3*16 +: 16] = 16'h4000;
      fb_coef[5*16 +: 16] = 16'h2000;
      for (int k = 0; k < 20; k++) shift_one(12'(k * 37 + 1), 2'(k));
      drain();

      // R2 R6: full-scale random mix
      for (int i = 0; i < FF_TAPS; i++) ff_coef[i*16 +: 16] = (i % 2) ? 16'h7fff : 16'h8000;
      for (int i = 0; i < FB_TAPS; i++) fb_coef[i*16 +: 16] = 16'($urandom);
      for (int k = 0; k < 100; k++)
         shift_one((k % 2) ? 12'h7ff : 12'h800, 2'($urandom));
      drain();

      check(expq.size() == 0, "R7 results outstanding", expq.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule